// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block is the refresh-control slice of an SDRAM controller. A programmable interval counter measures the time between auto-refresh operations. The interval is set in steps of 16 bus clocks. When the interval expires, the block raises a refresh request. The request stays up until the main memory sequencer reports an idle bus. One refresh command is then issued, and the interval restarts. Every refresh is followed by a recovery window during which activate commands are blocked. The length of that window comes from a 2-bit code. Both memory blocks behind the controller share the one timer and the one recovery setting.

A software control bit moves the SDRAM into self-refresh and brings it back out. Entry drops the clock-enable line and issues an entry command. Exit raises clock-enable and issues an exit command, followed by the normal recovery window. While the devices refresh themselves, the interval counter is frozen. A second control bit says that the clock-enable pin carries command information instead. In that case the self-refresh bit is ignored.

Top module: `sdram_refresh_seq`

## Requirements
- R1: After reset, rfsh_req, ref_cmd, self_entry and self_exit are 0, while cke_out and act_allow are 1.
- R2: While rfsh_en is 0, the interval counter is held at zero and rfsh_req stays 0, whatever the other inputs do.
- R3: With rfsh_en high, rfsh_req rises once the block has counted P = (rfsh_count+1)*16 clocks. The count starts from clear, and each clock edge with rfsh_en high counts. The clock edge that issues a refresh counts as the first clock of the next interval. As a result, under a permanent grant, ref_cmd pulses are exactly P cycles apart.
- R4: A pending rfsh_req holds until bus_idle is sampled high. At that point ref_cmd is high for exactly one cycle, and rfsh_req falls in that same cycle. A refresh is also held back while a recovery window is running or the block is in self-refresh.
- R5: act_allow is low in the cycle of ref_cmd and in the N cycles that follow. N is set by rcv_code: 2'b00 gives 3, 2'b01 gives 6, and 2'b10 or 2'b11 gives 9.
- R6: Self-refresh entry needs all of the following: selfref_req=1, cke_is_cmd=0, bus_idle=1, no pending refresh, and no recovery window running. When they hold, self_entry pulses for one cycle. cke_out goes low in that same cycle and stays low while in self-refresh.
- R7: Clearing selfref_req while in self-refresh gives a one-cycle self_exit pulse. cke_out rises in that same cycle. act_allow then stays low for the N+1 cycles given in R5.
- R8: The interval counter is frozen during self-refresh, so no ref_cmd issues there. After exit, counting resumes from the held value.
- R9: With cke_is_cmd=1, selfref_req has no effect: no self_entry occurs, cke_out stays 1, and refreshes continue.
- R10: At most one of ref_cmd, self_entry and self_exit is high in any cycle, and act_allow is 0 throughout self-refresh.
- R11: When a refresh is pending and entry is requested, the refresh is issued first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_en | input | 1 | Enables the interval counter |
| rfsh_count | input | 9 | Interval in 16-clock steps, minus one |
| rcv_code | input | 2 | Post-refresh recovery code |
| selfref_req | input | 1 | Software request to hold the SDRAM in self-refresh |
| cke_is_cmd | input | 1 | Clock-enable pin carries command information |
| bus_idle | input | 1 | Idle-bus grant from the main sequencer |
| rfsh_req | output | 1 | Refresh pending |
| ref_cmd | output | 1 | Auto-refresh command strobe |
| self_entry | output | 1 | Self-refresh entry command strobe |
| self_exit | output | 1 | Self-refresh exit command strobe |
| cke_out | output | 1 | SDRAM clock enable |
| act_allow | output | 1 | Activate permitted |

## Verification
The bench first runs the timer with the grant held high at the shortest interval and at the 624-clock setting. This checks the refresh spacing with no waiting. It then withholds the grant for long stretches, which separates a request that is held from one that is dropped or repeated. Each of the four recovery codes is exercised, so that a wrong code mapping shows up in act_allow. Self-refresh is tried three ways: with the clock-enable pin in normal use, with it carrying commands, and with entry requested while a refresh is already pending. Together these show the counter freeze, the effect of the command-mode bit and the refresh-first priority.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;
  localparam int RC_W  = 9;
  localparam int STEP  = 16;
  localparam int PER_W = $clog2(STEP << RC_W) + 1;
  localparam int REC_W = 4;

  typedef enum logic {ST_ACTIVE, ST_SELFREF} sr_state_e;

  // refresh interval in bus clocks: (count + 1) * STEP
  function automatic logic [PER_W-1:0] refresh_period(input logic [RC_W-1:0] cnt);
    return (PER_W'(cnt) + PER_W'(1)) * PER_W'(STEP);
  endfunction

  // clocks inserted between a refresh/exit and the next activate
  function automatic logic [REC_W-1:0] recovery_gap(input logic [1:0] code);
    case (code)
      2'b00:   return REC_W'(3);
      2'b01:   return REC_W'(6);
      default: return REC_W'(9);
    endcase
  endfunction
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
  import sdram_refresh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic             fire,
  input  logic [PER_W-1:0] period,
  output logic             pend
);
  logic [PER_W-1:0] cnt;
  logic             expire;

  assign expire = (cnt >= period - PER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (fire) begin
      pend <= 1'b0;
      cnt  <= PER_W'(1);
    end else if (run && !pend) begin
      if (expire) begin
        pend <= 1'b1;
        cnt  <= '0;
      end else begin
        cnt <= cnt + PER_W'(1);
      end
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend && en && !fire |=> pend); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    en && !run && !fire |=> $stable(cnt)); // R8
  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pend && cnt == '0); // R2
endmodule

// File: rtl/rfsh_recovery_timer.sv
module rfsh_recovery_timer
  import sdram_refresh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REC_W-1:0] gap,
  output logic             idle
);
  logic [REC_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)            left <= '0;
    else if (load)         left <= gap + REC_W'(1);
    else if (left != '0)   left <= left - REC_W'(1);
  end

  assign idle = (left == '0);

  AST_REC_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && !load |=> left == $past(left) - REC_W'(1)); // R5
endmodule

// File: rtl/selfref_fsm.sv
module selfref_fsm
  import sdram_refresh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic cke_cmd,
  input  logic gnt,
  input  logic pend,
  input  logic rec_idle,
  output logic in_self,
  output logic enter_go,
  output logic exit_go,
  output logic entry_q,
  output logic exit_q,
  output logic cke_q
);
  sr_state_e st;

  assign in_self  = (st == ST_SELFREF);
  assign enter_go = !in_self && req && !cke_cmd && gnt && !pend && rec_idle;
  assign exit_go  = in_self && !req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_ACTIVE;
      entry_q <= 1'b0;
      exit_q  <= 1'b0;
      cke_q   <= 1'b1;
    end else begin
      entry_q <= enter_go;
      exit_q  <= exit_go;
      if (enter_go) begin
        st    <= ST_SELFREF;
        cke_q <= 1'b0;
      end else if (exit_go) begin
        st    <= ST_ACTIVE;
        cke_q <= 1'b1;
      end
    end
  end

  AST_CKE_LOW_IN_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    in_self |-> !cke_q); // R6
  AST_EXIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_self && !req |=> !in_self && exit_q); // R7
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdram_refresh_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rfsh_en,
  input  logic [RC_W-1:0] rfsh_count,
  input  logic [1:0]      rcv_code,
  input  logic            selfref_req,
  input  logic            cke_is_cmd,
  input  logic            bus_idle,
  output logic            rfsh_req,
  output logic            ref_cmd,
  output logic            self_entry,
  output logic            self_exit,
  output logic            cke_out,
  output logic            act_allow
);
  logic [PER_W-1:0] period;
  logic [REC_W-1:0] gap;
  logic             pend, rec_idle, in_self;
  logic             ref_go, enter_go, exit_go;

  assign period = refresh_period(rfsh_count);
  assign gap    = recovery_gap(rcv_code);
  assign ref_go = pend && bus_idle && !in_self && rec_idle;

  rfsh_interval_timer u_timer (
    .clk(clk), .rst_n(rst_n), .en(rfsh_en), .run(!in_self),
    .fire(ref_go), .period(period), .pend(pend)
  );

  rfsh_recovery_timer u_rec (
    .clk(clk), .rst_n(rst_n), .load(ref_go || exit_go),
    .gap(gap), .idle(rec_idle)
  );

  selfref_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(selfref_req), .cke_cmd(cke_is_cmd),
    .gnt(bus_idle), .pend(pend), .rec_idle(rec_idle), .in_self(in_self),
    .enter_go(enter_go), .exit_go(exit_go), .entry_q(self_entry),
    .exit_q(self_exit), .cke_q(cke_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ref_cmd <= 1'b0;
    else        ref_cmd <= ref_go;
  end

  assign rfsh_req  = pend;
  assign act_allow = rec_idle && !in_self;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_cmd, self_entry, self_exit})); // R10
  AST_REF_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> $past(bus_idle)); // R4
  AST_REF_BLOCKS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> !act_allow && !rfsh_req); // R5
  AST_ENTRY_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    self_entry |-> !cke_out); // R6
  AST_EXIT_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    self_exit |-> cke_out && !act_allow); // R7
  AST_NO_SELF_CMDMODE: assert property (@(posedge clk) disable iff (!rst_n)
    self_entry |-> !$past(cke_is_cmd)); // R9
  AST_NO_REF_IN_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_out && !self_exit |-> !ref_cmd); // R8
endmodule

// File: tb/test_sdram_refresh_seq.sv
module test_sdram_refresh_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rfsh_en = 1'b0;
  logic [8:0] rfsh_count = '0;
  logic [1:0] rcv_code = '0;
  logic       selfref_req = 1'b0;
  logic       cke_is_cmd = 1'b0;
  logic       bus_idle = 1'b0;
  logic       rfsh_req, ref_cmd, self_entry, self_exit, cke_out, act_allow;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sdram_refresh_seq i_sdram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .rfsh_en(rfsh_en), .rfsh_count(rfsh_count),
    .rcv_code(rcv_code), .selfref_req(selfref_req), .cke_is_cmd(cke_is_cmd),
    .bus_idle(bus_idle), .rfsh_req(rfsh_req), .ref_cmd(ref_cmd),
    .self_entry(self_entry), .self_exit(self_exit), .cke_out(cke_out),
    .act_allow(act_allow)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_elapsed, m_block;
  bit m_pend, m_self, m_cke, m_ref, m_in, m_out;
  bit live = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_elapsed = 0; m_block = 0; m_pend = 0; m_self = 0;
      m_cke = 1; m_ref = 0; m_in = 0; m_out = 0;
      live = 1;
    end else begin
      int  need, hold;
      bit  was_self, go_ref, go_in, go_out;
      need     = (int'(rfsh_count) + 1) * 16;
      hold     = (rcv_code == 2'b00) ? 3 : (rcv_code == 2'b01) ? 6 : 9;
      was_self = m_self;
      go_ref   = m_pend && bus_idle && !m_self && m_block == 0;
      go_in    = !m_self && selfref_req && !cke_is_cmd && bus_idle && !m_pend && m_block == 0;
      go_out   = m_self && !selfref_req;
      m_ref = go_ref; m_in = go_in; m_out = go_out;
      if (go_in)  begin m_self = 1; m_cke = 0; end
      if (go_out) begin m_self = 0; m_cke = 1; end
      if (go_ref || go_out) m_block = hold + 1;
      else if (m_block > 0) m_block--;
      if (!rfsh_en) begin m_elapsed = 0; m_pend = 0; end
      else if (go_ref) begin m_pend = 0; m_elapsed = 1; end
      else if (!was_self && !m_pend) begin
        m_elapsed++;
        if (m_elapsed >= need) begin m_pend = 1; m_elapsed = 0; end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (live && !done) begin
      chk("R3", "rfsh_req",   rfsh_req,   m_pend);
      chk("R4", "ref_cmd",    ref_cmd,    m_ref);
      chk("R6", "self_entry", self_entry, m_in);
      chk("R7", "self_exit",  self_exit,  m_out);
      chk("R6", "cke_out",    cke_out,    m_cke);
      chk("R5", "act_allow",  act_allow,  (m_block == 0 && !m_self));
      chk("R10", "strobe count", int'(ref_cmd) + int'(self_entry) + int'(self_exit) > 1, 0);
      if (!cke_out) chk("R10", "act_allow in self-refresh", act_allow, 0);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // waits for the next ref_cmd; returns the cycle, or -1 after the limit
  task automatic wait_ref(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (ref_cmd) begin at = cyc; return; end
    end
  endtask

  initial begin
    int t0, t1, n;
    idle_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rfsh_req",  rfsh_req,  0);
    chk("R1", "ref_cmd",   ref_cmd,   0);
    chk("R1", "self_entry", self_entry, 0);
    chk("R1", "cke_out",   cke_out,   1);
    chk("R1", "act_allow", act_allow, 1);

    // R2: disabled timer, grant high, never requests
    bus_idle = 1'b1;
    n = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); n += rfsh_req; end
    chk("R2", "requests while disabled", n, 0);

    // R3: shortest interval, permanent grant
    rfsh_count = 9'd0; rcv_code = 2'b00; rfsh_en = 1'b1;
    wait_ref(100, t0);
    wait_ref(100, t1);
    chk("R3", "refresh spacing P=16", t1 - t0, 16);
    idle_cycles(40);

    // R4: withheld grant, request held, single command
    rfsh_en = 1'b0; @(negedge clk);
    rfsh_count = 9'd2; rcv_code = 2'b01; bus_idle = 1'b0; rfsh_en = 1'b1;
    n = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); n += ref_cmd; end
    chk("R4", "refreshes without grant", n, 0);
    chk("R4", "request held", rfsh_req, 1);
    bus_idle = 1'b1;
    n = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); n += ref_cmd; end
    chk("R4", "one command per request", n, 1);
    idle_cycles(100);

    // R5: remaining recovery codes
    rcv_code = 2'b10; idle_cycles(100);
    rcv_code = 2'b11; idle_cycles(100);

    // R6/R7/R8: self-refresh with normal clock enable
    selfref_req = 1'b1;
    for (int i = 0; i < 60 && cke_out; i++) @(negedge clk);
    chk("R6", "cke low after entry", cke_out, 0);
    n = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); n += ref_cmd; end
    chk("R8", "refreshes in self-refresh", n, 0);
    selfref_req = 1'b0;
    idle_cycles(2);
    chk("R7", "cke high after exit", cke_out, 1);
    idle_cycles(150);

    // R9: clock enable carries commands
    cke_is_cmd = 1'b1; selfref_req = 1'b1;
    n = 0;
    t0 = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); n += self_entry; t0 += ref_cmd;
    end
    chk("R9", "entries in command mode", n, 0);
    chk("R9", "refreshes continue", t0 > 0, 1);
    selfref_req = 1'b0; cke_is_cmd = 1'b0;
    idle_cycles(20);

    // R11: entry requested while a refresh is pending
    rfsh_en = 1'b0; rfsh_count = 9'd0; rcv_code = 2'b00; bus_idle = 1'b0;
    @(negedge clk);
    rfsh_en = 1'b1;
    for (int i = 0; i < 40 && !rfsh_req; i++) @(negedge clk);
    selfref_req = 1'b1;
    @(negedge clk);
    bus_idle = 1'b1;
    @(negedge clk);
    chk("R11", "refresh issued first", ref_cmd, 1);
    chk("R11", "no entry with refresh", self_entry, 0);
    idle_cycles(30);
    chk("R11", "entry follows", cke_out, 0);
    selfref_req = 1'b0;
    idle_cycles(40);

    // R3: worked example, 624-clock interval
    rfsh_en = 1'b0; @(negedge clk);
    rfsh_count = 9'd38; rfsh_en = 1'b1;
    wait_ref(700, t0);
    wait_ref(700, t1);
    chk("R3", "refresh spacing P=624", t1 - t0, 624);
    idle_cycles(20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule